// File: doc/BRIEF.md
# Channel-Indexed DMA Register File

This block is the register front end of a multi-channel DMA engine. Software reaches it through a plain 32-bit register port with a write strobe, an 8-bit byte offset and a read-data bus that follows the address with no wait. The block holds the engine's configuration and drives it out as wires. The data movement itself is done elsewhere.

Each channel has its own set of registers: control, descriptor base, descriptor length, interrupt status and interrupt enable. All of these sets share one window of offsets. A channel-select register decides which set that window reaches. The per-port control registers are reached the same way, through a port-select register. Global registers sit beside the window:
- engine reset
- polling control
- a global interrupt enable mask with one bit per channel

Hardware event inputs latch into each channel's status. Software clears status by writing ones. Each channel drives one interrupt line. The line is high when the channel has a pending source that is enabled and the channel's bit in the global mask is set.

A channel reset is started by software and clears itself. Software polls the reset bit until it reads zero.

Top module: `dma_regfile`

## Requirements
- R1: After rst_n, every register reads 0 and every output is 0. The offsets are:
  - 0x10 engine reset
  - 0x14 polling control
  - 0x18 channel select
  - 0x1C channel control
  - 0x20 descriptor base
  - 0x24 descriptor length
  - 0x28 interrupt status
  - 0x2C interrupt enable
  - 0x40 port select
  - 0x44 port control
  - 0xF4 global interrupt enable

  Any other offset reads 0.
- R2: Reads and writes at 0x1C, 0x20, 0x24, 0x28 and 0x2C act only on the channel whose number was last written to 0x18. The other channels keep their values.
- R3: Channel control has these fields:
  - bit 0: on, driven on ch_on[n]
  - bit 1: reset busy
  - bit 8: transmit direction, driven on ch_tx[n]
  - bits 17:16: weight, driven on ch_weight[2n+1:2n]

  All other bits read 0.
- R4: If the channel select holds a value of NUM_CH or more, writes at 0x1C to 0x2C change no channel, and reads there return 0. The port select works the same way for 0x44 when it holds NUM_PORT or more.
- R5: Writing control with bit 1 set starts a reset. Bit 1 reads 1 for exactly RST_CYCLES (4) cycles after the write edge. On the next edge, bit 1 and the on bit both clear. Writing bit 1 again while the reset runs does not restart it.
- R6: For each channel there are ST_W (8) status bits.
  - An event input bit set to 1 for a cycle sets the matching status bit.
  - Writing a 1 to a status bit clears it, and a 0 leaves it. Writing 0x7E clears bits 6:1 and keeps bits 0 and 7.
  - Bit 3 is the descriptor-complete source.
- R7: If an event sets a status bit in the same cycle that software clears it, the bit ends up set.
- R8: ch_irq[n] is high exactly when both of these hold:
  - some status bit of channel n is also set in that channel's enable register;
  - bit n of the global enable (0xF4) is 1.
- R9: Port control keeps only bits 11:8 (endian swap), bit 6 (packet drop) and bits 5:2 (two burst fields). Other bits read 0. It is banked by 0x40, and port n drives port_cfg[12n+11:12n] as bits 11:0.
- R10: Polling control keeps bit 31 (poll enable, on poll_en) and bit 6 (divide-by-4, on poll_div4). All other bits read 0.
- R11: Writing 0x10 with bit 0 set clears, on that edge, every register: the banked sets, the selects, the polling control and the global enable. Offset 0x10 always reads 0.
- R12: Descriptor base keeps all 32 bits. Descriptor length keeps the low LEN_W (16) bits, and the upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_set | input | NUM_CH*ST_W | Event set pulses; channel n owns bits [n*ST_W +: ST_W] |
| ch_on | output | NUM_CH | Channel on |
| ch_tx | output | NUM_CH | Channel transmit direction |
| ch_weight | output | 2*NUM_CH | Channel weight, 2 bits per channel |
| ch_irq | output | NUM_CH | Per-channel interrupt line |
| poll_en | output | 1 | Descriptor polling enable |
| poll_div4 | output | 1 | Polling clock divide-by-4 select |
| port_cfg | output | 12*NUM_PORT | Port control bits 11:0, one field per port |

## Verification
The bench writes to two channels and reads each back. A design that decoded the select wrongly would leak one channel's control or status into another. It then parks the select out of range. A design that truncated the select to its index width would write into channel 0 instead of ignoring the access.

The channel reset is timed edge by edge. Letting the reset bit go early or late, or leaving the on bit set afterwards, shows up on a specific poll.

Clearing status with 0x7E checks that set bits outside the mask survive. Raising an event in the same cycle as a clear catches a design where the clear wins. The interrupt line is checked with the global mask bit off and with the channel enable off. A design that ignored either gate would raise the line.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;

    // Register offsets (byte addresses within the block window)
    localparam logic [7:0] OFS_GCTRL = 8'h10;
    localparam logic [7:0] OFS_POLL  = 8'h14;
    localparam logic [7:0] OFS_CSEL  = 8'h18;
    localparam logic [7:0] OFS_CCTRL = 8'h1C;
    localparam logic [7:0] OFS_DBASE = 8'h20;
    localparam logic [7:0] OFS_DLEN  = 8'h24;
    localparam logic [7:0] OFS_CSTAT = 8'h28;
    localparam logic [7:0] OFS_CIEN  = 8'h2C;
    localparam logic [7:0] OFS_PSEL  = 8'h40;
    localparam logic [7:0] OFS_PCTRL = 8'h44;
    localparam logic [7:0] OFS_GIEN  = 8'hF4;

    // Channel control field positions
    localparam int CC_ON  = 0;
    localparam int CC_RST = 1;
    localparam int CC_TX  = 8;
    localparam int CC_WLO = 16;

    // Port control: width kept and the bits that are implemented
    localparam int          PCFG_W    = 12;
    localparam logic [11:0] PCFG_MASK = 12'hF7C;

    // Which banked channel register an offset selects
    typedef enum logic [2:0] {
        CREG_NONE,
        CREG_CTRL,
        CREG_BASE,
        CREG_LEN,
        CREG_STAT,
        CREG_IEN
    } creg_e;

    function automatic creg_e decode_creg(input logic [7:0] a);
        case (a)
            OFS_CCTRL: return CREG_CTRL;
            OFS_DBASE: return CREG_BASE;
            OFS_DLEN:  return CREG_LEN;
            OFS_CSTAT: return CREG_STAT;
            OFS_CIEN:  return CREG_IEN;
            default:   return CREG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
    import dma_regfile_pkg::*;
#(
    parameter int ST_W       = 8,
    parameter int LEN_W      = 16,
    parameter int RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_clr,
    input  logic             wr,
    input  creg_e            reg_id,
    input  logic [31:0]      wdata,
    input  logic [ST_W-1:0]  ev_set,
    output logic [31:0]      ctrl_rd,
    output logic [31:0]      base_rd,
    output logic [31:0]      len_rd,
    output logic [31:0]      stat_rd,
    output logic [31:0]      ien_rd,
    output logic             on,
    output logic             tx,
    output logic [1:0]       weight,
    output logic             busy,
    output logic             pending
);

    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    typedef struct packed {
        logic             on;
        logic             busy;
        logic             tx;
        logic [1:0]       weight;
        logic [CNT_W-1:0] cnt;
        logic [31:0]      base;
        logic [LEN_W-1:0] len;
        logic [ST_W-1:0]  st;
        logic [ST_W-1:0]  ien;
    } chan_t;

    chan_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr) begin
            case (reg_id)
                CREG_CTRL: begin
                    s_d.on     = wdata[CC_ON];
                    s_d.tx     = wdata[CC_TX];
                    s_d.weight = wdata[CC_WLO+1:CC_WLO];
                    if (wdata[CC_RST] && !s_q.busy) begin
                        s_d.busy = 1'b1;
                        s_d.cnt  = CNT_W'(RST_CYCLES - 1);
                    end
                end
                CREG_BASE: s_d.base = wdata;
                CREG_LEN:  s_d.len  = wdata[LEN_W-1:0];
                CREG_STAT: s_d.st   = s_q.st & ~wdata[ST_W-1:0];
                CREG_IEN:  s_d.ien  = wdata[ST_W-1:0];
                default: ;
            endcase
        end
        // running reset: completion clears on and busy together
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
                s_d.on   = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        // hardware events win over a software clear
        s_d.st = s_d.st | ev_set;
        if (eng_clr) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_rd = {14'b0, s_q.weight, 7'b0, s_q.tx, 6'b0, s_q.busy, s_q.on};
    assign base_rd = s_q.base;
    assign len_rd  = 32'(s_q.len);
    assign stat_rd = 32'(s_q.st);
    assign ien_rd  = 32'(s_q.ien);
    assign on      = s_q.on;
    assign tx      = s_q.tx;
    assign weight  = s_q.weight;
    assign busy    = s_q.busy;
    assign pending = |(s_q.st & s_q.ien);

endmodule

// File: rtl/dma_port_bank.sv
module dma_port_bank
    import dma_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_clr,
    input  logic              wr,
    input  logic [31:0]       wdata,
    output logic [31:0]       cfg_rd,
    output logic [PCFG_W-1:0] cfg
);

    typedef struct packed {
        logic [PCFG_W-1:0] cfg;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (wr)      p_d.cfg = wdata[PCFG_W-1:0] & PCFG_MASK;
        if (eng_clr) p_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign cfg_rd = 32'(p_q.cfg);
    assign cfg    = p_q.cfg;

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_regfile_pkg::*;
#(
    parameter int NUM_CH     = 20,
    parameter int NUM_PORT   = 5,
    parameter int ST_W       = 8,
    parameter int LEN_W      = 16,
    parameter int RST_CYCLES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [7:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_CH*ST_W-1:0]     ev_set,
    output logic [NUM_CH-1:0]          ch_on,
    output logic [NUM_CH-1:0]          ch_tx,
    output logic [2*NUM_CH-1:0]        ch_weight,
    output logic [NUM_CH-1:0]          ch_irq,
    output logic                       poll_en,
    output logic                       poll_div4,
    output logic [PCFG_W*NUM_PORT-1:0] port_cfg
);

    localparam int CSEL_W = (NUM_CH > 1)   ? $clog2(NUM_CH)   : 1;
    localparam int PSEL_W = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1;

    typedef struct packed {
        logic [31:0]       csel;
        logic [31:0]       psel;
        logic              poll_en;
        logic              poll_div4;
        logic [NUM_CH-1:0] gie;
    } glb_t;

    glb_t g_d, g_q;

    logic              eng_clr;
    creg_e             creg;
    logic              csel_ok, psel_ok;
    logic [CSEL_W-1:0] csel_idx;
    logic [PSEL_W-1:0] psel_idx;
    logic [NUM_CH-1:0] gie_vec;
    logic [NUM_CH-1:0] ch_busy;
    logic [NUM_CH-1:0] ch_pend;
    logic [NUM_CH*ST_W-1:0] st_flat;

    logic [31:0] ctrl_rd [NUM_CH];
    logic [31:0] base_rd [NUM_CH];
    logic [31:0] len_rd  [NUM_CH];
    logic [31:0] stat_rd [NUM_CH];
    logic [31:0] ien_rd  [NUM_CH];
    logic [31:0] pcfg_rd [NUM_PORT];

    assign eng_clr  = bus_wr && (bus_addr == OFS_GCTRL) && bus_wdata[0];
    assign creg     = decode_creg(bus_addr);
    assign csel_ok  = g_q.csel < 32'(NUM_CH);
    assign psel_ok  = g_q.psel < 32'(NUM_PORT);
    assign csel_idx = g_q.csel[CSEL_W-1:0];
    assign psel_idx = g_q.psel[PSEL_W-1:0];
    assign gie_vec  = g_q.gie;

    // global registers
    always_comb begin
        g_d = g_q;
        if (bus_wr) begin
            case (bus_addr)
                OFS_CSEL: g_d.csel = bus_wdata;
                OFS_PSEL: g_d.psel = bus_wdata;
                OFS_POLL: begin
                    g_d.poll_en   = bus_wdata[31];
                    g_d.poll_div4 = bus_wdata[6];
                end
                OFS_GIEN: g_d.gie = bus_wdata[NUM_CH-1:0];
                default: ;
            endcase
        end
        if (eng_clr) g_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign poll_en   = g_q.poll_en;
    assign poll_div4 = g_q.poll_div4;

    // banked channel register sets
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic ch_wr;
        assign ch_wr = bus_wr && (creg != CREG_NONE) && csel_ok
                       && (csel_idx == CSEL_W'(c));

        dma_chan_bank #(
            .ST_W       (ST_W),
            .LEN_W      (LEN_W),
            .RST_CYCLES (RST_CYCLES)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .eng_clr (eng_clr),
            .wr      (ch_wr),
            .reg_id  (creg),
            .wdata   (bus_wdata),
            .ev_set  (ev_set[c*ST_W +: ST_W]),
            .ctrl_rd (ctrl_rd[c]),
            .base_rd (base_rd[c]),
            .len_rd  (len_rd[c]),
            .stat_rd (stat_rd[c]),
            .ien_rd  (ien_rd[c]),
            .on      (ch_on[c]),
            .tx      (ch_tx[c]),
            .weight  (ch_weight[2*c +: 2]),
            .busy    (ch_busy[c]),
            .pending (ch_pend[c])
        );

        assign ch_irq[c] = ch_pend[c] & g_q.gie[c];
        assign st_flat[c*ST_W +: ST_W] = stat_rd[c][ST_W-1:0];
    end

    // banked port control registers
    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        logic pt_wr;
        assign pt_wr = bus_wr && (bus_addr == OFS_PCTRL) && psel_ok
                       && (psel_idx == PSEL_W'(p));

        dma_port_bank u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .eng_clr (eng_clr),
            .wr      (pt_wr),
            .wdata   (bus_wdata),
            .cfg_rd  (pcfg_rd[p]),
            .cfg     (port_cfg[PCFG_W*p +: PCFG_W])
        );
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_POLL:  bus_rdata = {g_q.poll_en, 24'b0, g_q.poll_div4, 6'b0};
            OFS_CSEL:  bus_rdata = g_q.csel;
            OFS_CCTRL: if (csel_ok) bus_rdata = ctrl_rd[csel_idx];
            OFS_DBASE: if (csel_ok) bus_rdata = base_rd[csel_idx];
            OFS_DLEN:  if (csel_ok) bus_rdata = len_rd[csel_idx];
            OFS_CSTAT: if (csel_ok) bus_rdata = stat_rd[csel_idx];
            OFS_CIEN:  if (csel_ok) bus_rdata = ien_rd[csel_idx];
            OFS_PSEL:  bus_rdata = g_q.psel;
            OFS_PCTRL: if (psel_ok) bus_rdata = pcfg_rd[psel_idx];
            OFS_GIEN:  bus_rdata = 32'(g_q.gie);
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
    parameter int NUM_CH     = 20,
    parameter int ST_W       = 8,
    parameter int RST_CYCLES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic [7:0]             bus_addr,
    input logic [31:0]            bus_wdata,
    input logic [NUM_CH*ST_W-1:0] ev_set,
    input logic [NUM_CH-1:0]      ch_on,
    input logic [NUM_CH-1:0]      ch_irq,
    input logic [NUM_CH-1:0]      gie,
    input logic [NUM_CH-1:0]      busy,
    input logic [NUM_CH*ST_W-1:0] st_flat
);

    logic eng_wr;
    assign eng_wr = bus_wr && (bus_addr == 8'h10) && bus_wdata[0];

    // R8: an interrupt line never rises without its global mask bit
    a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_irq & ~gie) == '0);

    // R11: engine reset leaves every channel off and the mask clear
    a_r11_engine_clear: assert property (@(posedge clk) disable iff (!rst_n)
        eng_wr |=> (ch_on == '0) && (gie == '0) && (busy == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        int unsigned bcnt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       bcnt_q <= 0;
            else if (busy[c]) bcnt_q <= bcnt_q + 1;
            else              bcnt_q <= 0;
        end

        // R5: reset busy never lasts longer than RST_CYCLES cycles
        a_r5_reset_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            busy[c] |-> (bcnt_q < RST_CYCLES));

        // R5: when the reset finishes the channel is off
        a_r5_reset_drops_on: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy[c]) |-> !ch_on[c]);

        // R7: an event bit is always present in status on the next cycle
        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ((|ev_set[c*ST_W +: ST_W]) && !eng_wr) |=>
            ((st_flat[c*ST_W +: ST_W] & $past(ev_set[c*ST_W +: ST_W]))
              == $past(ev_set[c*ST_W +: ST_W])));
    end

endmodule

bind dma_regfile dma_regfile_chk #(
    .NUM_CH     (NUM_CH),
    .ST_W       (ST_W),
    .RST_CYCLES (RST_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ev_set    (ev_set),
    .ch_on     (ch_on),
    .ch_irq    (ch_irq),
    .gie       (gie_vec),
    .busy      (ch_busy),
    .st_flat   (st_flat)
);

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb;

    localparam int NUM_CH   = 20;
    localparam int NUM_PORT = 5;
    localparam int ST_W     = 8;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      bus_wr = 1'b0;
    logic [7:0]                bus_addr = '0;
    logic [31:0]               bus_wdata = '0;
    logic [31:0]               bus_rdata;
    logic [NUM_CH*ST_W-1:0]    ev_set = '0;
    logic [NUM_CH-1:0]         ch_on, ch_tx, ch_irq;
    logic [2*NUM_CH-1:0]       ch_weight;
    logic                      poll_en, poll_div4;
    logic [12*NUM_PORT-1:0]    port_cfg;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    dma_regfile u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ev_set    (ev_set),
        .ch_on     (ch_on),
        .ch_tx     (ch_tx),
        .ch_weight (ch_weight),
        .ch_irq    (ch_irq),
        .poll_en   (poll_en),
        .poll_div4 (poll_div4),
        .port_cfg  (port_cfg)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_ev(input int ch, input logic [7:0] bits);
        ev_set[ch*ST_W +: ST_W] = bits;
        @(negedge clk);
        ev_set = '0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        rd_reg(8'h1C, d); check("R1 ctrl after reset", d, 0);
        rd_reg(8'hF4, d); check("R1 gie after reset", d, 0);
        rd_reg(8'h14, d); check("R1 poll after reset", d, 0);
        check("R1 ch_on after reset", 32'(ch_on), 0);
        check("R1 port_cfg after reset", port_cfg[31:0], 0);
        rd_reg(8'h30, d); check("R1 unmapped offset", d, 0);
    endtask

    task automatic t_banking();
        logic [31:0] d;
        wr_reg(8'h18, 3);  wr_reg(8'h1C, 32'h0003_0101);
        wr_reg(8'h18, 7);  wr_reg(8'h1C, 32'h0000_0001);
        rd_reg(8'h1C, d); check("R2 ch7 ctrl", d, 32'h1);
        wr_reg(8'h18, 3);
        rd_reg(8'h1C, d); check("R2 ch3 ctrl", d, 32'h0003_0101);
        check("R3 ch_on", 32'(ch_on), 32'h88);
        check("R3 ch_tx", 32'(ch_tx), 32'h08);
        check("R3 ch_weight ch3", 32'(ch_weight[7:6]), 3);
        wr_reg(8'h18, 19); wr_reg(8'h20, 32'hDEAD_BEEF); wr_reg(8'h24, 32'hFFFF_1234);
        wr_reg(8'h18, 0);  wr_reg(8'h20, 32'h0000_1000);
        rd_reg(8'h20, d); check("R2 ch0 base", d, 32'h0000_1000);
        wr_reg(8'h18, 19);
        rd_reg(8'h20, d); check("R12 ch19 base 32 bits", d, 32'hDEAD_BEEF);
        rd_reg(8'h24, d); check("R12 ch19 length width", d, 32'h0000_1234);
    endtask

    task automatic t_out_of_range();
        logic [31:0] d;
        wr_reg(8'h18, 20);
        wr_reg(8'h1C, 32'h0000_0101);
        rd_reg(8'h1C, d); check("R4 read with bad select", d, 0);
        check("R4 no channel turned on", 32'(ch_on), 32'h88);
        wr_reg(8'h18, 32'h20);
        wr_reg(8'h1C, 32'h0000_0001);
        check("R4 select not truncated", 32'(ch_on), 32'h88);
        wr_reg(8'h18, 0);
        rd_reg(8'h1C, d); check("R4 ch0 untouched", d, 0);
    endtask

    task automatic t_chan_reset();
        logic [31:0] d;
        wr_reg(8'h18, 5);
        wr_reg(8'h1C, 32'h3);
        rd_reg(8'h1C, d); check("R5 reset bit set after write", d, 32'h3);
        check("R5 on during reset", 32'(ch_on[5]), 1);
        @(negedge clk); @(negedge clk);
        wr_reg(8'h1C, 32'h3); // restart attempt while busy is ignored
        rd_reg(8'h1C, d); check("R5 busy in last cycle", d, 32'h3);
        @(negedge clk);
        rd_reg(8'h1C, d); check("R5 reset self-cleared", d, 0);
        check("R5 on cleared by reset", 32'(ch_on[5]), 0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        wr_reg(8'h18, 2);
        wr_reg(8'h2C, 32'h08);
        wr_reg(8'hF4, 32'h4);
        pulse_ev(2, 8'h89);
        rd_reg(8'h28, d); check("R6 status latched", d, 32'h89);
        check("R8 irq raised", 32'(ch_irq), 32'h4);
        wr_reg(8'h28, 32'h7E);
        rd_reg(8'h28, d); check("R6 ack clears 6:1 only", d, 32'h81);
        check("R8 irq dropped after ack", 32'(ch_irq), 0);
        // clear and set of bit 3 in the same cycle
        bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h08;
        ev_set[2*ST_W + 3] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ev_set = '0;
        rd_reg(8'h28, d); check("R7 set beats clear", d, 32'h89);
        check("R8 irq with mask and enable", 32'(ch_irq), 32'h4);
        wr_reg(8'hF4, 0);
        check("R8 global mask gates irq", 32'(ch_irq), 0);
        wr_reg(8'hF4, 32'h4);
        wr_reg(8'h2C, 32'h0);
        check("R8 channel enable gates irq", 32'(ch_irq), 0);
        wr_reg(8'h18, 4);
        rd_reg(8'h28, d); check("R2 other channel status", d, 0);
    endtask

    task automatic t_ports();
        logic [31:0] d;
        wr_reg(8'h40, 0); wr_reg(8'h44, 32'h0000_0F40);
        wr_reg(8'h40, 1); wr_reg(8'h44, 32'h0000_0014);
        wr_reg(8'h40, 2); wr_reg(8'h44, 32'hFFFF_FFFF);
        rd_reg(8'h44, d); check("R9 port2 mask", d, 32'h0000_0F7C);
        wr_reg(8'h40, 0);
        rd_reg(8'h44, d); check("R9 port0 readback", d, 32'h0000_0F40);
        check("R9 port_cfg0", 32'(port_cfg[11:0]), 32'hF40);
        check("R9 port_cfg1", 32'(port_cfg[23:12]), 32'h014);
        wr_reg(8'h40, 5); wr_reg(8'h44, 32'h0000_0F00);
        rd_reg(8'h44, d); check("R4 bad port select reads 0", d, 0);
        check("R4 bad port select writes none", 32'(port_cfg[59:48]), 0);
    endtask

    task automatic t_poll();
        logic [31:0] d;
        wr_reg(8'h14, 32'hFFFF_FFFF);
        rd_reg(8'h14, d); check("R10 poll mask", d, 32'h8000_0040);
        check("R10 poll outputs", {30'b0, poll_en, poll_div4}, 32'h3);
        wr_reg(8'h14, 32'h0000_0040);
        check("R10 poll_en off", {30'b0, poll_en, poll_div4}, 32'h1);
    endtask

    task automatic t_engine_reset();
        logic [31:0] d;
        wr_reg(8'h10, 32'h0); // bit 0 clear: nothing happens
        check("R11 no reset without bit 0", 32'(ch_on), 32'h88);
        wr_reg(8'h10, 32'h1);
        check("R11 channels off", 32'(ch_on), 0);
        check("R11 port cfg cleared", port_cfg[31:0], 0);
        check("R11 poll cleared", {30'b0, poll_en, poll_div4}, 0);
        rd_reg(8'hF4, d); check("R11 gie cleared", d, 0);
        rd_reg(8'h18, d); check("R11 select cleared", d, 0);
        wr_reg(8'h18, 3);
        rd_reg(8'h1C, d); check("R11 ch3 ctrl cleared", d, 0);
        wr_reg(8'h18, 2);
        rd_reg(8'h28, d); check("R11 ch2 status cleared", d, 0);
        rd_reg(8'h10, d); check("R11 gctrl reads 0", d, 0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_banking();
        t_out_of_range();
        t_chan_reset();
        t_status();
        t_ports();
        t_poll();
        t_engine_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule